// File: doc/BRIEF.md
# Systolic Edge-Function Coverage Engine

This block finds which pixels of a screen tile lie inside one triangle. It takes three edge equations, each of the form E = A*x + B*y + C, and the screen position of the tile's corner. It then reports coverage for the 32x16 pixel tile as thirty-two 4x4 pixel groups, one group per clock. Each result carries a 16-bit coverage mask and the group's 5-bit position inside the tile. A separate traversal-order memory downstream consumes these masks.

The tile is split into eight 8x8 blocks, and each block into four groups. Each pixel coordinate is formed as tile origin plus block position plus pixel offset. The edge value at the tile corner is computed once per triangle by a serial shift-and-add over the bits of the tile coordinates. The offset of a group within the tile and the offset of a pixel within the group are small integers, so both are formed by a shallow tree of shifted coefficient copies. The 48 per-pixel sums (three edges by sixteen pixels) run through a bit-serial carry pipeline. Each stage resolves one 7-bit slice of the 28-bit value, least significant first, and hands its carry to the next stage through a register. The sign is known when the top slice is resolved.

A controller with four states sequences the work. IDLE waits for start; on start it goes to SETUP. SETUP runs one serial step per tile-coordinate bit, then goes to ISSUE. ISSUE feeds one group per clock into the pipeline and, after the last group, goes to DRAIN. DRAIN goes back to IDLE on the edge at which the last group reaches the output, so a new triangle can be started in the cycle that carries done.

Top module: `edge_cover_engine`

## Requirements
- R1: After reset, out_valid and done are low. They stay low until a start is accepted.
- R2: A start sampled high in IDLE is accepted, and coef_a, coef_b, coef_c, tile_x and tile_y are captured on that edge. Later changes on those inputs have no effect on the run. Group 0 appears at the output TCW+NSL clock edges after the accepting edge (14 with the default parameters, NSL = W/SL).
- R3: An accepted start yields exactly 32 outputs, on 32 consecutive cycles, with out_group counting 0, 1, ..., 31. The group index encodes position as follows. Bit 0 selects the right group column within the block. Bit 1 selects the lower group row within the block. Bits 3:2 give the block column. Bit 4 gives the block row.
- R4: Mask bit py*4+px refers to the pixel at x = tile_x + 8*g[3:2] + 4*g[0] + px and y = tile_y + 8*g[4] + 4*g[1] + py, where px and py run from 0 to 3. That bit is 1 exactly when all three edge values at the pixel are non-negative. The edge values are evaluated as signed 28-bit integers; coef_a and coef_b are 16-bit signed and coef_c is 28-bit signed.
- R5: A pixel where an edge value is exactly zero counts as covered by that edge.
- R6: done is high for exactly one cycle, together with the output for group 31. out_valid is low in the following cycle unless a new run has reached the output.
- R7: A start while the controller is not in IDLE is ignored. The run in flight finishes unchanged, and no extra outputs follow it.
- R8: A start in the cycle that carries done is accepted, and the new run keeps the latency stated in R2.
- R9: Coverage stays correct when edge values reach magnitudes of 2^20 and more, where carries cross every slice boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a triangle (accepted in IDLE only) |
| coef_a | input | 3x16 | Signed x coefficient of each edge |
| coef_b | input | 3x16 | Signed y coefficient of each edge |
| coef_c | input | 3x28 | Signed constant term of each edge |
| tile_x | input | 10 | Screen x of the tile corner |
| tile_y | input | 10 | Screen y of the tile corner |
| out_valid | output | 1 | A group result is present |
| out_group | output | 5 | Position of the group in the tile |
| out_mask | output | 16 | Coverage of the group, bit py*4+px |
| done | output | 1 | Marks the last group of the tile |

## Verification
The bench builds the block with its default parameters: 28-bit values in four 7-bit slices, 16-bit slopes and 10-bit tile coordinates. With these values the latency is a fixed 14 cycles, and a tile placed near coordinate 1000 with slopes near 30000 pushes edge values into the top slice, so every inter-slice carry gets exercised. The directed runs cover full and empty coverage, a general triangle, edges passing exactly through pixel centres, a start ignored in the middle of a run and a back-to-back start in the done cycle. Every mask is compared against a full-width integer model of the three edges.

// File: rtl/ecov_pkg.sv
package ecov_pkg;
    localparam int EDGES    = 3;
    localparam int GRP_SIDE = 4;
    localparam int GRP_PIX  = GRP_SIDE * GRP_SIDE;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SETUP = 2'd1,
        ST_ISSUE = 2'd2,
        ST_DRAIN = 2'd3
    } ecov_state_t;
endpackage

// File: rtl/ecov_setup.sv
// Serial shift-and-add: origin = A*tx + B*ty + C, one coordinate bit per step.
module ecov_setup #(
    parameter int W   = 28,
    parameter int TCW = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step,
    input  logic signed [W-1:0] a_in,
    input  logic signed [W-1:0] b_in,
    input  logic signed [W-1:0] c_in,
    input  logic [TCW-1:0]      tx,
    input  logic [TCW-1:0]      ty,
    output logic signed [W-1:0] origin
);
    logic signed [W-1:0] acc, a_sh, b_sh;
    logic [TCW-1:0]      x_sh, y_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc  <= '0;
            a_sh <= '0;
            b_sh <= '0;
            x_sh <= '0;
            y_sh <= '0;
        end else if (load) begin
            acc  <= c_in;
            a_sh <= a_in;
            b_sh <= b_in;
            x_sh <= tx;
            y_sh <= ty;
        end else if (step) begin
            acc  <= acc + (x_sh[0] ? a_sh : '0) + (y_sh[0] ? b_sh : '0);
            a_sh <= a_sh <<< 1;
            b_sh <= b_sh <<< 1;
            x_sh <= x_sh >> 1;
            y_sh <= y_sh >> 1;
        end
    end

    assign origin = acc;
endmodule

// File: rtl/ecov_lane.sv
// Bit-serial carry pipeline: one SL-bit slice per stage, LSB slice first.
module ecov_lane #(
    parameter int W  = 28,
    parameter int SL = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] op_a,
    input  logic [W-1:0] op_b,
    output logic         neg
);
    localparam int NSL = W / SL;
    localparam logic [SL:0]   SLICE_MAX = {1'b0, {SL{1'b1}}};
    localparam logic [SL-1:0] LOW_MAX   = {1'b0, {(SL-1){1'b1}}};

    logic [W-1:0] ra [NSL-1];
    logic [W-1:0] rb [NSL-1];
    logic         rc [NSL-1];
    logic [W-1:0] xa [NSL];
    logic [W-1:0] xb [NSL];
    logic         xc [NSL];
    logic         cy [NSL-1];

    always_comb begin
        xa[0] = op_a;
        xb[0] = op_b;
        xc[0] = 1'b0;
        for (int k = 1; k < NSL; k++) begin
            xa[k] = ra[k-1];
            xb[k] = rb[k-1];
            xc[k] = rc[k-1];
        end
        for (int k = 0; k < NSL - 1; k++) begin
            cy[k] = ({1'b0, xa[k][SL-1:0]} + {1'b0, xb[k][SL-1:0]}
                     + {{SL{1'b0}}, xc[k]}) > SLICE_MAX;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < NSL - 1; k++) begin
                ra[k] <= '0;
                rb[k] <= '0;
                rc[k] <= 1'b0;
            end
            neg <= 1'b0;
        end else begin
            for (int k = 0; k < NSL - 1; k++) begin
                ra[k] <= xa[k] >> SL;
                rb[k] <= xb[k] >> SL;
                rc[k] <= cy[k];
            end
            // sign of the top slice: msb operands xor carry into the msb
            neg <= xa[NSL-1][SL-1] ^ xb[NSL-1][SL-1]
                 ^ (({1'b0, xa[NSL-1][SL-2:0]} + {1'b0, xb[NSL-1][SL-2:0]}
                     + {{(SL-1){1'b0}}, xc[NSL-1]}) > LOW_MAX);
        end
    end
endmodule

// File: rtl/ecov_ctrl.sv
module ecov_ctrl
    import ecov_pkg::*;
#(
    parameter int TCW = 10,
    parameter int NSL = 4,
    parameter int GIW = 5
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start,
    output logic           load,
    output logic           step,
    output logic           issue,
    output logic [GIW-1:0] issue_grp,
    output logic           out_valid,
    output logic [GIW-1:0] out_group,
    output logic           done
);
    localparam int GROUPS = 1 << GIW;
    localparam int CMAX   = (TCW > GROUPS) ? TCW : GROUPS;
    localparam int CNTW   = $clog2(CMAX) + 1;
    localparam logic [GIW-1:0]  LAST_G   = GIW'(GROUPS - 1);
    localparam logic [CNTW-1:0] SETUP_END = CNTW'(TCW - 1);
    localparam logic [CNTW-1:0] ISSUE_END = CNTW'(GROUPS - 1);

    ecov_state_t     state, nxt;
    logic [CNTW-1:0] cnt;
    logic [NSL-1:0]  vpipe;
    logic [GIW-1:0]  gpipe [NSL];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt <= '0;
        else if (state != nxt)   cnt <= '0;
        else if (step || issue)  cnt <= cnt + CNTW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vpipe <= '0;
            for (int k = 0; k < NSL; k++) gpipe[k] <= '0;
        end else begin
            vpipe <= {vpipe[NSL-2:0], issue};
            gpipe[0] <= issue_grp;
            for (int k = 1; k < NSL; k++) gpipe[k] <= gpipe[k-1];
        end
    end

    always_comb begin
        nxt   = state;
        load  = 1'b0;
        step  = 1'b0;
        issue = 1'b0;
        unique case (state)
            ST_IDLE: begin
                load = start;
                if (start) nxt = ST_SETUP;
            end
            ST_SETUP: begin
                step = 1'b1;
                if (cnt == SETUP_END) nxt = ST_ISSUE;
            end
            ST_ISSUE: begin
                issue = 1'b1;
                if (cnt == ISSUE_END) nxt = ST_DRAIN;
            end
            ST_DRAIN: begin
                if (vpipe[NSL-2] && gpipe[NSL-2] == LAST_G) nxt = ST_IDLE;
            end
        endcase
    end

    assign issue_grp = cnt[GIW-1:0];
    assign out_valid = vpipe[NSL-1];
    assign out_group = gpipe[NSL-1];
    assign done      = vpipe[NSL-1] && (gpipe[NSL-1] == LAST_G);
endmodule

// File: rtl/edge_cover_engine.sv
module edge_cover_engine
    import ecov_pkg::*;
#(
    parameter int W   = 28,
    parameter int SL  = 7,
    parameter int CIW = 16,
    parameter int TCW = 10,
    parameter int BXB = 2,
    parameter int BYB = 1,
    localparam int GIW = 2 + BXB + BYB
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [EDGES-1:0][CIW-1:0]  coef_a,
    input  logic [EDGES-1:0][CIW-1:0]  coef_b,
    input  logic [EDGES-1:0][W-1:0]    coef_c,
    input  logic [TCW-1:0]             tile_x,
    input  logic [TCW-1:0]             tile_y,
    output logic                       out_valid,
    output logic [GIW-1:0]             out_group,
    output logic [GRP_PIX-1:0]         out_mask,
    output logic                       done
);
    localparam int NSL = W / SL;

    function automatic logic signed [W-1:0] mul_small(input logic signed [W-1:0] v,
                                                      input logic [7:0] k);
        logic signed [W-1:0] r;
        r = '0;
        for (int i = 0; i < 8; i++) begin
            if (k[i]) r = r + (v <<< i);
        end
        return r;
    endfunction

    logic                load, step, issue;
    logic [GIW-1:0]      issue_grp;
    logic signed [W-1:0] a_l [EDGES];
    logic signed [W-1:0] b_l [EDGES];
    logic signed [W-1:0] origin [EDGES];
    logic signed [W-1:0] gbase [EDGES];
    logic signed [W-1:0] poff [EDGES][GRP_PIX];
    logic [EDGES-1:0][GRP_PIX-1:0] neg;
    logic [BXB:0]        xi;
    logic [BYB:0]        yi;

    ecov_ctrl #(.TCW(TCW), .NSL(NSL), .GIW(GIW)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(start),
        .load(load), .step(step), .issue(issue), .issue_grp(issue_grp),
        .out_valid(out_valid), .out_group(out_group), .done(done)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int e = 0; e < EDGES; e++) begin
                a_l[e] <= '0;
                b_l[e] <= '0;
            end
        end else if (load) begin
            for (int e = 0; e < EDGES; e++) begin
                a_l[e] <= {{(W-CIW){coef_a[e][CIW-1]}}, coef_a[e]};
                b_l[e] <= {{(W-CIW){coef_b[e][CIW-1]}}, coef_b[e]};
            end
        end
    end

    // group offset in units of 4 pixels
    assign xi = {issue_grp[2+BXB-1:2], issue_grp[0]};
    assign yi = {issue_grp[GIW-1:2+BXB], issue_grp[1]};

    for (genvar e = 0; e < EDGES; e++) begin : g_edge
        ecov_setup #(.W(W), .TCW(TCW)) u_setup (
            .clk(clk), .rst_n(rst_n), .load(load), .step(step),
            .a_in({{(W-CIW){coef_a[e][CIW-1]}}, coef_a[e]}),
            .b_in({{(W-CIW){coef_b[e][CIW-1]}}, coef_b[e]}),
            .c_in(coef_c[e]),
            .tx(tile_x), .ty(tile_y),
            .origin(origin[e])
        );

        assign gbase[e] = origin[e] + (mul_small(a_l[e], 8'(xi)) <<< 2)
                                    + (mul_small(b_l[e], 8'(yi)) <<< 2);

        for (genvar p = 0; p < GRP_PIX; p++) begin : g_pix
            assign poff[e][p] = mul_small(a_l[e], 8'(p % GRP_SIDE))
                              + mul_small(b_l[e], 8'(p / GRP_SIDE));
            ecov_lane #(.W(W), .SL(SL)) u_lane (
                .clk(clk), .rst_n(rst_n),
                .op_a(gbase[e]), .op_b(poff[e][p]),
                .neg(neg[e][p])
            );
        end
    end

    for (genvar p = 0; p < GRP_PIX; p++) begin : g_mask
        assign out_mask[p] = ~(neg[0][p] | neg[1][p] | neg[2][p]);
    end
endmodule

// File: rtl/ecov_checker.sv
module ecov_checker #(
    parameter int TCW = 10,
    parameter int NSL = 4,
    parameter int GIW = 5
) (
    input logic           clk,
    input logic           rst_n,
    input logic           load,
    input logic           out_valid,
    input logic [GIW-1:0] out_group,
    input logic           done
);
    localparam logic [GIW-1:0] LAST_G = {GIW{1'b1}};

    logic       pending;
    logic [7:0] since_load;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      pending <= 1'b0;
        else if (load)   pending <= 1'b1;
        else if (done)   pending <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   since_load <= 8'hFF;
        else if (load)                since_load <= 8'd0;
        else if (since_load != 8'hFF) since_load <= since_load + 8'd1;
    end

    a_r2_first_latency: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> since_load == 8'(TCW + NSL));

    a_r3_first_group_zero: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |-> out_group == '0);

    a_r3_group_step: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && out_group != LAST_G) |=>
            (out_valid && out_group == $past(out_group) + GIW'(1)));

    a_r6_quiet_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !out_valid);

    a_r6_done_needs_run: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> pending);

    a_r7_load_when_free: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (!pending || done));
endmodule

bind edge_cover_engine ecov_checker #(.TCW(TCW), .NSL(W / SL), .GIW(GIW)) u_chk (
    .clk(clk), .rst_n(rst_n), .load(load),
    .out_valid(out_valid), .out_group(out_group), .done(done)
);

// File: tb/edge_cover_engine_bench.sv
`timescale 1ns/100ps
module edge_cover_engine_bench;
    localparam int TCW = 10;
    localparam int NSL = 4;
    localparam int LAT = TCW + NSL;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [2:0][15:0]  coef_a = '0;
    logic [2:0][15:0]  coef_b = '0;
    logic [2:0][27:0]  coef_c = '0;
    logic [9:0]        tile_x = '0;
    logic [9:0]        tile_y = '0;
    logic              out_valid;
    logic [4:0]        out_group;
    logic [15:0]       out_mask;
    logic              done;

    int checks = 0;
    int fails  = 0;
    int ta [3];
    int tb [3];
    int tc [3];
    int ttx, tty;
    logic [15:0] got [32];

    edge_cover_engine u_edge_cover_engine (
        .clk(clk), .rst_n(rst_n), .start(start),
        .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .tile_x(tile_x), .tile_y(tile_y),
        .out_valid(out_valid), .out_group(out_group),
        .out_mask(out_mask), .done(done)
    );

    always #2.5 clk = ~clk;

    initial begin
        #(5.0 * 100000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] exp_mask(input int g);
        logic [15:0] m;
        for (int p = 0; p < 16; p++) begin
            longint x = longint'(ttx + 8 * ((g >> 2) & 3) + 4 * (g & 1) + (p & 3));
            longint y = longint'(tty + 8 * (g >> 4) + 4 * ((g >> 1) & 1) + (p >> 2));
            m[p] = 1'b1;
            for (int e = 0; e < 3; e++) begin
                longint v = longint'(ta[e]) * x + longint'(tb[e]) * y + longint'(tc[e]);
                if (v < 0) m[p] = 1'b0;
            end
        end
        return m;
    endfunction

    // Called at a negedge; returns at the negedge of the done cycle.
    task automatic run_tri(input string mreq, input string lreq, input bit poke);
        int lat;
        for (int e = 0; e < 3; e++) begin
            coef_a[e] = 16'(ta[e]);
            coef_b[e] = 16'(tb[e]);
            coef_c[e] = 28'(tc[e]);
        end
        tile_x = 10'(ttx);
        tile_y = 10'(tty);
        start  = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int e = 0; e < 3; e++) begin   // R2: captured values must be used
            coef_a[e] = 16'h5A5A ^ 16'(e);
            coef_b[e] = 16'hA5C3;
            coef_c[e] = 28'h0F0F0F0;
        end
        tile_x = 10'h2AA;
        tile_y = 10'h155;
        lat = 0;
        while (!out_valid && lat < 40) begin
            @(posedge clk);
            lat++;
            @(negedge clk);
        end
        chk(lat == LAT, lreq, "latency to first group", lat, LAT);
        for (int i = 0; i < 32; i++) begin
            chk(out_valid == 1'b1, "R3", "out_valid during run", out_valid, 1);
            chk(out_group == 5'(i), "R3", "group order", out_group, i);
            chk(out_mask == exp_mask(i), mreq, "coverage mask", out_mask, exp_mask(i));
            chk(done == (i == 31), "R6", "done placement", done, (i == 31));
            got[i] = out_mask;
            start = (poke && i == 5);
            if (i < 31) @(negedge clk);
        end
        start = 1'b0;
    endtask

    task automatic quiet(input int n, input string req);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            chk(out_valid == 1'b0 && done == 1'b0, req, "no output", out_valid, 0);
        end
    endtask

    task automatic set_edge(input int e, input int a, input int b, input int c);
        ta[e] = a;
        tb[e] = b;
        tc[e] = c;
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
        chk(done == 1'b0, "R1", "done after reset", done, 0);
        quiet(6, "R1");
    endtask

    task automatic t_full_cover;
        ttx = 0; tty = 0;
        for (int e = 0; e < 3; e++) set_edge(e, 0, 0, 1);
        run_tri("R4", "R2", 1'b0);
        chk(got[17] == 16'hFFFF, "R4", "full coverage mask", got[17], 16'hFFFF);
        quiet(1, "R6");
    endtask

    task automatic t_triangle;
        ttx = 64; tty = 32;
        set_edge(0, 5, 3, -500);
        set_edge(1, -4, 1, 420);
        set_edge(2, -1, -6, 520);
        run_tri("R4", "R2", 1'b0);
        quiet(2, "R6");
    endtask

    task automatic t_zero_edge;
        ttx = 128; tty = 48;
        set_edge(0, 1, 0, -(128 + 13));
        set_edge(1, 0, 1, -(48 + 5));
        set_edge(2, -1, -1, 128 + 48 + 40);
        run_tri("R5", "R2", 1'b0);
        // x offset 13 -> block col 1, right group, px 1; y offset 5 -> lower group, py 1
        chk(got[7][5] == 1'b1, "R5", "pixel on two zero edges", got[7][5], 1);
        chk(got[7][4] == 1'b0, "R5", "pixel left of zero edge", got[7][4], 0);
        quiet(2, "R6");
    endtask

    task automatic t_large;
        ttx = 992; tty = 1008;
        set_edge(0, -30000, 25000, 29760000 - 25200000 + 300000);
        set_edge(1, 20000, -7, -19840000 + 7056 + 200000);
        set_edge(2, 1, 1, 0);
        run_tri("R9", "R2", 1'b0);
        quiet(2, "R6");
    endtask

    task automatic t_busy_start;
        ttx = 320; tty = 16;
        set_edge(0, 7, -2, -2300);
        set_edge(1, -3, 5, 1000);
        set_edge(2, -2, -4, 850);
        run_tri("R7", "R2", 1'b1);
        quiet(24, "R7");
    endtask

    task automatic t_back_to_back;
        ttx = 96; tty = 64;
        for (int e = 0; e < 3; e++) set_edge(e, 0, 0, -1);
        run_tri("R4", "R2", 1'b0);
        chk(got[0] == 16'h0000, "R4", "empty coverage mask", got[0], 0);
        ttx = 512; tty = 256;
        set_edge(0, 2, 9, -5000);
        set_edge(1, -6, 1, 3300);
        set_edge(2, 3, -8, 1700);
        run_tri("R4", "R8", 1'b0);
        quiet(2, "R6");
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_full_cover();
        t_triangle();
        t_zero_edge();
        t_large();
        t_busy_start();
        t_back_to_back();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule